// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches sixteen external lines and turns their level changes into interrupt requests and event pulses. Line n takes pin n from one of several input ports. A 4-bit selector per line picks the port, and the selectors sit four to a 32-bit configuration word. Each pin level passes through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one before it.

Each line has its own enables for the rising and falling trigger, and both may be on together. An interrupt mask and a separate event mask decide whether a detected edge produces a latched interrupt, a one-cycle event pulse, both, or neither. Latched interrupts are held in a pending register until software clears them by writing 1 to their bits. A simple word-addressed bus, with a write strobe and a combinational read, gives access to the configuration and pending state.

Word addresses: 0 rising enables, 1 falling enables, 2 interrupt mask, 3 event mask, 4 pending (read, write-1-to-clear), and 8 to 11 port selectors. Bit n of each mask-type word belongs to line n, and bits 31:16 of every word read back as 0.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, all enables, masks, selectors and pending bits are 0, and `irq_req` and `evt_pulse` are 0.
- R2: The words at addresses 0 to 3 and 8 to 11 read back the low 16 bits last written to them, and bits 31:16 of every read are 0.
- R3: Line n follows pin n of port p (`port_pins[p*16+n]`), where p is the field at bits 4*(n%4)+3:4*(n%4) of word 8+n/4. A field value of 4 or more holds the line low.
- R4: A rising edge on a line with its rising enable and event mask set gives `evt_pulse[n]` = 1 for exactly one cycle. That cycle is the one after the second clock edge that samples the new pin level.
- R5: A falling edge behaves the same way under the falling enable. With both enables set, each change of level triggers.
- R6: An edge whose direction is not enabled produces no event and sets no pending bit.
- R7: An enabled edge on a line whose interrupt mask is 1 sets its pending bit at the third sampling edge. The pending bits read at address 4. With the interrupt mask at 0, no pending bit is set.
- R8: `irq_req[n]` is the pending bit of line n ANDed with its interrupt mask bit. Clearing the mask hides the request but keeps the pending bit.
- R9: Writing 1 to a bit at address 4 clears that pending bit. Writing 0 leaves it unchanged, and nothing else clears it.
- R10: When a new interrupt edge and a write-1 clear reach the same line in the same cycle, the pending bit stays set.
- R11: An event pulse sets no pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_pins | input | NUM_PORTS*NUM_LINES | Pin levels, port p pin n at index p*NUM_LINES+n |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_req | output | NUM_LINES | Per-line interrupt request level |
| evt_pulse | output | NUM_LINES | Per-line one-cycle event pulse |

## Verification
The hardest case to reach from the ports is a write-1 clear and a fresh interrupt edge landing on the same line in the same cycle. Because of the synchronizer, the edge lands three clock edges after the pin moves. The bench places the pin change two cycles before it issues the clear write, so that both arrive at the same edge, and it reads back the pending word afterwards. A constrained-random phase also reprograms selectors while pins toggle, which makes edges appear purely from re-routing. A cycle-accurate reference model in the bench tracks those edges.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int EIC_DATA_W       = 32;
    localparam int EIC_SEL_W        = 4;
    localparam int EIC_SEL_PER_WORD = 4;

    localparam int EIC_A_RISE     = 0;
    localparam int EIC_A_FALL     = 1;
    localparam int EIC_A_IMASK    = 2;
    localparam int EIC_A_EMASK    = 3;
    localparam int EIC_A_PEND     = 4;
    localparam int EIC_A_SEL_BASE = 8;

    typedef enum logic [2:0] {
        SLOT_NONE,
        SLOT_RISE,
        SLOT_FALL,
        SLOT_IMASK,
        SLOT_EMASK,
        SLOT_PEND,
        SLOT_SEL
    } reg_slot_e;

    function automatic reg_slot_e eic_decode(input int addr, input int sel_words);
        reg_slot_e s;
        s = SLOT_NONE;
        if (addr == EIC_A_RISE)       s = SLOT_RISE;
        else if (addr == EIC_A_FALL)  s = SLOT_FALL;
        else if (addr == EIC_A_IMASK) s = SLOT_IMASK;
        else if (addr == EIC_A_EMASK) s = SLOT_EMASK;
        else if (addr == EIC_A_PEND)  s = SLOT_PEND;
        else if (addr >= EIC_A_SEL_BASE && addr < EIC_A_SEL_BASE + sel_words) s = SLOT_SEL;
        return s;
    endfunction

endpackage

// File: rtl/eic_line_route.sv
// Per-line port multiplexer (R3): line n picks pin n of the selected port.
module eic_line_route #(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int SEL_W     = 4
) (
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic [NUM_LINES*SEL_W-1:0]     sel_flat,
    output logic [NUM_LINES-1:0]           line_lvl
);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        logic [SEL_W-1:0] sel;
        assign sel = sel_flat[n*SEL_W +: SEL_W];

        always_comb begin
            line_lvl[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel == SEL_W'(p)) line_lvl[n] = port_pins[p*NUM_LINES + n];
            end
        end
    end

endmodule

// File: rtl/eic_sync_edge.sv
// Two-flop synchronizer followed by a history flop; edges compare the last two samples.
module eic_sync_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_in,
    output logic [W-1:0] rise_det,
    output logic [W-1:0] fall_det
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= lvl_in;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign rise_det = sync_q & ~hist_q;
    assign fall_det = ~sync_q & hist_q;

endmodule

// File: rtl/eic_regs.sv
// Configuration words, pending register (W1C, set wins) and read mux.
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [EIC_DATA_W-1:0]          bus_wdata,
    output logic [EIC_DATA_W-1:0]          bus_rdata,
    input  logic [NUM_LINES-1:0]           set_hits,
    output logic [NUM_LINES-1:0]           rise_en,
    output logic [NUM_LINES-1:0]           fall_en,
    output logic [NUM_LINES-1:0]           imask,
    output logic [NUM_LINES-1:0]           emask,
    output logic [NUM_LINES-1:0]           pend,
    output logic [NUM_LINES*EIC_SEL_W-1:0] sel_flat
);

    localparam int FIELD_W   = EIC_SEL_PER_WORD * EIC_SEL_W;
    localparam int SEL_WORDS = NUM_LINES / EIC_SEL_PER_WORD;

    reg_slot_e                          slot;
    int                                 sel_idx;
    logic [NUM_LINES-1:0]               clr_bits;
    logic [SEL_WORDS-1:0][FIELD_W-1:0]  sel_q;
    logic                               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[EIC_DATA_W-1:NUM_LINES];

    always_comb begin
        slot    = eic_decode(int'(bus_addr), SEL_WORDS);
        sel_idx = int'(bus_addr) - EIC_A_SEL_BASE;
    end

    assign clr_bits = (bus_wr && slot == SLOT_PEND) ? bus_wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            imask   <= '0;
            emask   <= '0;
            sel_q   <= '0;
        end else if (bus_wr) begin
            unique case (slot)
                SLOT_RISE:  rise_en <= bus_wdata[NUM_LINES-1:0];
                SLOT_FALL:  fall_en <= bus_wdata[NUM_LINES-1:0];
                SLOT_IMASK: imask   <= bus_wdata[NUM_LINES-1:0];
                SLOT_EMASK: emask   <= bus_wdata[NUM_LINES-1:0];
                SLOT_SEL: begin
                    for (int w = 0; w < SEL_WORDS; w++) begin
                        if (w == sel_idx) sel_q[w] <= bus_wdata[FIELD_W-1:0];
                    end
                end
                SLOT_PEND, SLOT_NONE: ;
            endcase
        end
    end

    // R9/R10: clear by writing ones; a fresh hit in the same cycle is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_bits) | set_hits;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (slot)
            SLOT_RISE:  bus_rdata[NUM_LINES-1:0] = rise_en;
            SLOT_FALL:  bus_rdata[NUM_LINES-1:0] = fall_en;
            SLOT_IMASK: bus_rdata[NUM_LINES-1:0] = imask;
            SLOT_EMASK: bus_rdata[NUM_LINES-1:0] = emask;
            SLOT_PEND:  bus_rdata[NUM_LINES-1:0] = pend;
            SLOT_SEL: begin
                for (int w = 0; w < SEL_WORDS; w++) begin
                    if (w == sel_idx) bus_rdata[FIELD_W-1:0] = sel_q[w];
                end
            end
            SLOT_NONE: ;
        endcase
    end

    assign sel_flat = sel_q;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PORTS*NUM_LINES-1:0] port_pins,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [EIC_DATA_W-1:0]          bus_wdata,
    output logic [EIC_DATA_W-1:0]          bus_rdata,
    output logic [NUM_LINES-1:0]           irq_req,
    output logic [NUM_LINES-1:0]           evt_pulse
);

    logic [NUM_LINES-1:0]           line_lvl;
    logic [NUM_LINES-1:0]           rise_det;
    logic [NUM_LINES-1:0]           fall_det;
    logic [NUM_LINES-1:0]           trig_hit;
    logic [NUM_LINES-1:0]           set_hits;
    logic [NUM_LINES-1:0]           rise_en;
    logic [NUM_LINES-1:0]           fall_en;
    logic [NUM_LINES-1:0]           imask;
    logic [NUM_LINES-1:0]           emask;
    logic [NUM_LINES-1:0]           pend;
    logic [NUM_LINES*EIC_SEL_W-1:0] sel_flat;

    eic_line_route #(
        .NUM_LINES (NUM_LINES),
        .NUM_PORTS (NUM_PORTS),
        .SEL_W     (EIC_SEL_W)
    ) u_route (
        .port_pins (port_pins),
        .sel_flat  (sel_flat),
        .line_lvl  (line_lvl)
    );

    eic_sync_edge #(
        .W (NUM_LINES)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_in   (line_lvl),
        .rise_det (rise_det),
        .fall_det (fall_det)
    );

    eic_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .set_hits  (set_hits),
        .rise_en   (rise_en),
        .fall_en   (fall_en),
        .imask     (imask),
        .emask     (emask),
        .pend      (pend),
        .sel_flat  (sel_flat)
    );

    // R4/R5/R6: enabled edges; R7/R11: interrupt and event paths split by mask.
    assign trig_hit  = (rise_det & rise_en) | (fall_det & fall_en);
    assign set_hits  = trig_hit & imask;
    assign evt_pulse = trig_hit & emask;
    assign irq_req   = pend & imask;   // R8

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
    parameter int NL = 16,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] irq_req,
    input logic [NL-1:0] evt_pulse,
    input logic [NL-1:0] pend,
    input logic [NL-1:0] imask,
    input logic [NL-1:0] emask,
    input logic [NL-1:0] set_hits,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [NL-1:0] wdata_lo
);

    logic [NL-1:0] w1c;
    assign w1c = (bus_wr && bus_addr == AW'(4)) ? wdata_lo : '0;

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0 && evt_pulse == '0));

    a_r4_evt_needs_emask: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse & ~emask) == '0);

    a_r7_pend_set_needs_imask: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(imask)) == '0);

    a_r9_pend_clear_needs_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) & ~pend & ~$past(w1c)) == '0);

    a_r10_hit_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_hits) & ~pend) == '0);

endmodule

bind edge_irq_ctrl eic_checker #(.NL(NUM_LINES), .AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .evt_pulse (evt_pulse),
    .pend      (pend),
    .imask     (imask),
    .emask     (emask),
    .set_hits  (set_hits),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[NUM_LINES-1:0])
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;

    localparam int NL = 16;
    localparam int NP = 4;
    localparam int AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NP*NL-1:0] pins = '0;
    logic             bus_wr = 1'b0;
    logic [AW-1:0]    bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    wire  [31:0]      bus_rdata;
    wire  [NL-1:0]    irq_req;
    wire  [NL-1:0]    evt_pulse;

    edge_irq_ctrl u_edge_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_pins (pins),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .evt_pulse (evt_pulse)
    );

    int checks = 0;
    int fails  = 0;

    // Reference model built from the requirements.
    logic [NL-1:0]      m_rise, m_fall, m_im, m_em, m_pend, m_s1, m_s2, m_prev;
    logic [3:0][15:0]   m_sel;

    function automatic logic [NL-1:0] m_line(input logic [NP*NL-1:0] p, input logic [3:0][15:0] s);
        logic [NL-1:0] r;
        for (int n = 0; n < NL; n++) begin
            int sv;
            sv = int'(s[n/4][4*(n%4) +: 4]);
            r[n] = (sv < NP) ? p[sv*NL + n] : 1'b0;
        end
        return r;
    endfunction

    function automatic logic [NL-1:0] m_trig();
        return (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
    endfunction

    function automatic logic [31:0] m_read(input int a);
        logic [31:0] v;
        v = '0;
        case (a)
            0: v[15:0] = m_rise;
            1: v[15:0] = m_fall;
            2: v[15:0] = m_im;
            3: v[15:0] = m_em;
            4: v[15:0] = m_pend;
            8, 9, 10, 11: v[15:0] = m_sel[a-8];
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rise <= '0; m_fall <= '0; m_im <= '0; m_em <= '0; m_pend <= '0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_sel <= '0;
        end else begin
            logic [NL-1:0] clr;
            clr = (bus_wr && bus_addr == 4'd4) ? bus_wdata[15:0] : '0;
            m_s1   <= m_line(pins, m_sel);
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_pend <= (m_pend & ~clr) | (m_trig() & m_im);
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: m_rise <= bus_wdata[15:0];
                    1: m_fall <= bus_wdata[15:0];
                    2: m_im   <= bus_wdata[15:0];
                    3: m_em   <= bus_wdata[15:0];
                    8, 9, 10, 11: m_sel[int'(bus_addr)-8] <= bus_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
        chk("R8 irq_req vs model", 32'(irq_req), 32'(m_pend & m_im));
        chk("R4 R5 R6 evt_pulse vs model", 32'(evt_pulse), 32'(m_trig() & m_em));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = AW'(a);
        bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        bus_addr = AW'(a);
        #1;
        chk(req, bus_rdata, m_read(a));
        chk("R2 upper half zero", 32'(bus_rdata[31:16]), 32'h0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 irq_req at reset", 32'(irq_req), 32'h0);
        chk("R1 evt_pulse at reset", 32'(evt_pulse), 32'h0);
        for (int a = 0; a < 12; a++) begin
            bus_addr = AW'(a);
            #1;
            chk("R1 register zero at reset", bus_rdata, 32'h0);
        end
        rst_n = 1'b1;
        step();

        // R2: readback
        wr(0, 32'hA5A5_5A5A); rd(0, "R2 rise readback");
        wr(1, 32'h1234_8421); rd(1, "R2 fall readback");
        wr(2, 32'hFFFF_0F0F); rd(2, "R2 imask readback");
        wr(3, 32'h0000_F00F); rd(3, "R2 emask readback");
        wr(9, 32'hDEAD_BEEF); rd(9, "R2 sel readback");
        chk("R2 sel value", bus_rdata, 32'h0000_BEEF);
        for (int a = 0; a < 4; a++) wr(a, 32'h0);
        wr(9, 32'h0);
        repeat (4) step();

        // R4: rising edge timing on line 3, port 0
        wr(0, 32'h8); wr(3, 32'h8);
        pins[3] = 1'b1;
        step(); chk("R4 no pulse after first edge", 32'(evt_pulse[3]), 32'h0);
        step(); chk("R4 pulse after second edge", 32'(evt_pulse[3]), 32'h1);
        step(); chk("R4 pulse lasts one cycle", 32'(evt_pulse[3]), 32'h0);
        rd(4, "R11 event sets no pending");
        chk("R11 pending zero", 32'(bus_rdata), 32'h0);

        // R5: falling edge
        wr(1, 32'h8);
        pins[3] = 1'b0;
        step(); step(); chk("R5 falling pulse", 32'(evt_pulse[3]), 32'h1);
        step(); chk("R5 falling pulse ends", 32'(evt_pulse[3]), 32'h0);

        // R6: no trigger enabled on line 6
        wr(2, 32'h40); wr(3, 32'h48);
        pins[6] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(); chk("R6 no event without enable", 32'(evt_pulse[6]), 32'h0);
        end
        pins[6] = 1'b0;
        repeat (4) step();
        rd(4, "R6 pending read");
        chk("R6 no pending without enable", bus_rdata, 32'h0);

        // R3: line 5 from port 2 (word 9, bits 7:4)
        wr(9, 32'h20); wr(0, 32'h20); wr(2, 32'h20);
        repeat (4) step();
        pins[5] = 1'b1;
        repeat (4) step();
        chk("R3 unselected port ignored", 32'(irq_req[5]), 32'h0);
        pins[2*NL+5] = 1'b1;
        step(); step();
        chk("R3 not yet pending", 32'(irq_req[5]), 32'h0);
        step();
        chk("R3 selected port triggers", 32'(irq_req[5]), 32'h1);
        wr(4, 32'h20);
        chk("R9 clear line 5", 32'(irq_req[5]), 32'h0);
        wr(9, 32'h90);   // invalid port 9 holds line 5 low
        repeat (4) step();
        pins[5] = 1'b0; pins[NL+5] = 1'b0; pins[2*NL+5] = 1'b0; pins[3*NL+5] = 1'b0;
        repeat (3) step();
        pins[5] = 1'b1; pins[NL+5] = 1'b1; pins[2*NL+5] = 1'b1; pins[3*NL+5] = 1'b1;
        repeat (4) step();
        chk("R3 out-of-range selector holds line low", 32'(irq_req[5]), 32'h0);

        // R7/R8/R9: line 10, port 0
        wr(0, 32'h400); wr(2, 32'h400);
        pins[10] = 1'b1;
        repeat (3) step();
        chk("R7 pending after third edge", 32'(irq_req[10]), 32'h1);
        rd(4, "R7 pending read");
        wr(2, 32'h0);
        chk("R8 mask hides request", 32'(irq_req[10]), 32'h0);
        rd(4, "R8 pending retained");
        chk("R8 pending bit kept", 32'(bus_rdata[10]), 32'h1);
        wr(4, 32'h0);
        rd(4, "R9 write zero no effect");
        chk("R9 pending kept on zero write", 32'(bus_rdata[10]), 32'h1);
        wr(2, 32'h400);
        chk("R8 request returns with mask", 32'(irq_req[10]), 32'h1);
        wr(4, 32'h400);
        chk("R9 write one clears", 32'(irq_req[10]), 32'h0);

        // R10: clear and new edge in the same cycle
        pins[10] = 1'b0;
        repeat (4) step();
        pins[10] = 1'b1;
        repeat (3) step();
        chk("R10 setup pending", 32'(irq_req[10]), 32'h1);
        pins[10] = 1'b0;
        repeat (4) step();
        pins[10] = 1'b1;
        step(); step();
        wr(4, 32'h400);
        chk("R10 new edge beats clear", 32'(irq_req[10]), 32'h1);
        wr(4, 32'h400);
        chk("R10 plain clear afterwards", 32'(irq_req[10]), 32'h0);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 3) begin
                int a;
                logic [31:0] d;
                a = int'($urandom % 13);
                if (a >= 9) a = 4;
                else if (a >= 5) a = 8 + (a - 5);
                d = $urandom;
                if (a >= 8 && ($urandom % 4) != 0) d = d & 32'h3333;
                wr(a, d);
            end else if (r < 8) begin
                int idx;
                idx = int'($urandom % (NP*NL));
                pins[idx] = ~pins[idx];
                step();
            end else if (r == 8) begin
                int a;
                a = int'($urandom % 12);
                rd(a, "R2 R7 random readback");
                step();
            end else begin
                step();
            end
        end

        summary();
        $finish;
    end

endmodule